// File: doc/BRIEF.md
# Shifter Operand Generator with Carry

This block forms the second source operand of a data-processing instruction, together with the shifter carry that a logical instruction later copies into its carry flag. It is purely combinational. The decoder hands it the 32-bit instruction word, the value of the register to be shifted (Rm), the value of the register that may hold a shift amount (Rs), and the present carry flag. The operand, the carry and a flag that asks the sequencer for one extra cycle all settle in the same cycle.

Three operand forms are decoded from the word: an 8-bit constant rotated right by an even amount, Rm shifted by a 5-bit amount held in the word, and Rm shifted by the low byte of Rs. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. Within the immediate-amount form a rotate by zero encodes rotate-right-extended through the carry. Register reads, program-counter offsets and the ALU itself belong to the caller, which supplies adjusted register values. There is no handshake at the edge: the outputs follow the inputs within the cycle and the caller holds its inputs stable for as long as it uses the results.

Top module: `sop_gen`

## Requirements
- R1: When word bit 25 is 1 the operand is instr[7:0] zero-extended and rotated right by twice instr[11:8]; the carry is carry_in when instr[11:8] is zero, otherwise bit 31 of that operand.
- R2: When word bit 25 is 0, bit 4 picks the amount source (1: Rs bits 7:0, 0: instr[11:7]) and instr[6:5] picks the kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R3: extra_cycle is 1 exactly when bit 25 is 0 and bit 4 is 1.
- R4: A register amount of zero (Rs bits 7:0 all zero) returns Rm unchanged with carry_in as the carry, for all four kinds and whatever Rs holds above bit 7.
- R5: A nonzero amount n below 32 yields the ordinary shift or rotate of Rm; the carry is Rm bit 32−n for a left shift and Rm bit n−1 for the right shifts and the rotate.
- R6: A register logical left by exactly 32 gives 0 with carry Rm[0]; by more than 32 it gives 0 with carry 0.
- R7: A register logical right by exactly 32 gives 0 with carry Rm[31]; by more than 32 it gives 0 with carry 0.
- R8: A register arithmetic right by 32 or more gives every bit equal to Rm[31], and the carry is Rm[31].
- R9: A register rotate uses Rs bits 4:0 as the rotation; when those are zero but Rs bits 7:0 are not, the operand is Rm unchanged and the carry is Rm[31].
- R10: An immediate logical right of 0 acts as a shift by 32 (operand 0, carry Rm[31]); an immediate arithmetic right of 0 gives every bit equal to Rm[31] with carry Rm[31].
- R11: An immediate rotate of 0 is rotate-right-extended: operand {carry_in, Rm[31:1]}, carry Rm[0].
- R12: An immediate logical left of 0 returns Rm unchanged with carry_in as the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word holding the form, kind and amount fields |
| rm_val | input | DATA_W | Value to be shifted (Rm), already adjusted by the caller |
| rs_val | input | DATA_W | Value whose low byte is the register shift amount (Rs) |
| carry_in | input | 1 | Present carry flag |
| operand_out | output | DATA_W | Generated second operand |
| carry_out | output | 1 | Shifter carry |
| extra_cycle | output | 1 | Register-amount form needs one more cycle |

## Verification
The two functions that meet in one evaluation are the zero-amount pass-through and the out-of-range rules, since both read the same low bits of Rs: an Rs of 0x100, 32, 64 or 0xE0 has a zero rotation field yet differs in whether the full byte is zero. The bench sweeps every Rs byte value for each kind, with upper Rs bits set on some vectors and both carry-in levels, so the pass-through case (carry from carry_in) and the rotate-by-multiple-of-32 case (carry from Rm[31]) sit side by side. A behavioural model built on 64-bit shifts judges every vector, so a rule that picks the wrong branch shows as a wrong carry even when the operand happens to agree.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Instruction field positions; the decoder upstream relies on these.
  localparam int INSTR_W     = 32;
  localparam int IMM_FORM_B  = 25;
  localparam int REG_AMT_B   = 4;
  localparam int KIND_LO     = 5;
  localparam int IMM_AMT_LO  = 7;
  localparam int IMM_AMT_W   = 5;
  localparam int ROT_LO      = 8;
  localparam int ROT_W       = 4;
  localparam int CONST_W     = 8;
  localparam int REG_AMT_W   = 8;

  typedef enum logic [1:0] {
    SK_LEFT   = 2'b00,
    SK_RIGHT  = 2'b01,
    SK_ARITH  = 2'b10,
    SK_ROTATE = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic                  imm_form;
    logic                  reg_amt;
    shift_kind_e           kind;
    logic [IMM_AMT_W-1:0]  imm_amt;
    logic [ROT_W-1:0]      rot_field;
    logic [CONST_W-1:0]    const8;
  } sop_fields_t;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output sop_fields_t        fields
);

  logic unused_hi;

  always_comb begin
    fields.imm_form  = instr[IMM_FORM_B];
    fields.reg_amt   = instr[REG_AMT_B];
    fields.kind      = shift_kind_e'(instr[KIND_LO +: 2]);
    fields.imm_amt   = instr[IMM_AMT_LO +: IMM_AMT_W];
    fields.rot_field = instr[ROT_LO +: ROT_W];
    fields.const8    = instr[0 +: CONST_W];
  end

  // Upper opcode and register-number bits are decoded elsewhere.
  assign unused_hi = ^{instr[INSTR_W-1:IMM_FORM_B+1], instr[IMM_FORM_B-1:ROT_LO+ROT_W]};

endmodule

// File: rtl/sop_rotr.sv
module sop_rotr #(
  parameter int W = 32,
  localparam int LOG_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [LOG_W-1:0] amt,
  output logic [W-1:0]     dout
);

  logic [W-1:0] stage [0:LOG_W];

  assign stage[0] = din;

  for (genvar i = 0; i < LOG_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign stage[i+1] = amt[i] ? {stage[i][SH-1:0], stage[i][W-1:SH]} : stage[i];
  end

  assign dout = stage[LOG_W];

endmodule

// File: rtl/sop_imm_unit.sv
module sop_imm_unit
  import sop_pkg::*;
#(
  parameter int W = 32,
  localparam int LOG_W = $clog2(W)
) (
  input  logic [ROT_W-1:0]   rot_field,
  input  logic [CONST_W-1:0] const8,
  input  logic               cin,
  output logic [W-1:0]       op,
  output logic               cout
);

  logic [W-1:0]     widened;
  logic [LOG_W-1:0] rot_amt;
  logic [W-1:0]     rotated;

  assign widened = {{(W-CONST_W){1'b0}}, const8};
  assign rot_amt = LOG_W'({rot_field, 1'b0});

  sop_rotr #(.W(W)) u_rot (
    .din  (widened),
    .amt  (rot_amt),
    .dout (rotated)
  );

  always_comb begin
    op   = rotated;
    cout = (rot_field == '0) ? cin : rotated[W-1];
  end

endmodule

// File: rtl/sop_shift_unit.sv
module sop_shift_unit
  import sop_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = REG_AMT_W,
  localparam int LOG_W = $clog2(W)
) (
  input  logic [W-1:0]     val,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             is_reg,
  input  logic             cin,
  output logic [W-1:0]     op,
  output logic             cout
);

  logic [LOG_W-1:0] lo;
  logic [LOG_W-1:0] up_idx;
  logic [LOG_W-1:0] dn_idx;
  logic             zero_amt;
  logic             below_w;
  logic             exact_w;
  logic             sign;
  logic [W-1:0]     rot_out;

  assign lo       = amt[LOG_W-1:0];
  assign up_idx   = -lo;
  assign dn_idx   = lo - LOG_W'(1);
  assign zero_amt = (amt == '0);
  assign below_w  = (amt < AMT_W'(W));
  assign exact_w  = (amt == AMT_W'(W));
  assign sign     = val[W-1];

  sop_rotr #(.W(W)) u_rot (
    .din  (val),
    .amt  (lo),
    .dout (rot_out)
  );

  always_comb begin
    op   = val;
    cout = cin;
    unique case (kind)
      SK_LEFT: begin
        if (zero_amt) begin
          op   = val;
          cout = cin;
        end else if (below_w) begin
          op   = val << amt;
          cout = val[up_idx];
        end else if (exact_w) begin
          op   = '0;
          cout = val[0];
        end else begin
          op   = '0;
          cout = 1'b0;
        end
      end
      SK_RIGHT: begin
        if (zero_amt) begin
          if (is_reg) begin
            op   = val;
            cout = cin;
          end else begin
            op   = '0;
            cout = sign;
          end
        end else if (below_w) begin
          op   = val >> amt;
          cout = val[dn_idx];
        end else if (exact_w) begin
          op   = '0;
          cout = sign;
        end else begin
          op   = '0;
          cout = 1'b0;
        end
      end
      SK_ARITH: begin
        if (zero_amt) begin
          if (is_reg) begin
            op   = val;
            cout = cin;
          end else begin
            op   = {W{sign}};
            cout = sign;
          end
        end else if (below_w) begin
          op   = W'($signed(val) >>> amt);
          cout = val[dn_idx];
        end else begin
          op   = {W{sign}};
          cout = sign;
        end
      end
      SK_ROTATE: begin
        if (zero_amt) begin
          if (is_reg) begin
            op   = val;
            cout = cin;
          end else begin
            op   = {cin, val[W-1:1]};
            cout = val[0];
          end
        end else if (lo == '0) begin
          op   = val;
          cout = sign;
        end else begin
          op   = rot_out;
          cout = val[dn_idx];
        end
      end
      default: begin
        op   = val;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/sop_gen.sv
module sop_gen
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  operand_out,
  output logic               carry_out,
  output logic               extra_cycle
);

  localparam int AMT_W = REG_AMT_W;

  sop_fields_t       f;
  logic [AMT_W-1:0]  shamt;
  logic [DATA_W-1:0] imm_op;
  logic              imm_c;
  logic [DATA_W-1:0] sh_op;
  logic              sh_c;
  logic              unused_rs;

  sop_decode u_dec (
    .instr  (instr_word),
    .fields (f)
  );

  assign shamt     = f.reg_amt ? rs_val[AMT_W-1:0] : AMT_W'(f.imm_amt);
  assign unused_rs = ^rs_val[DATA_W-1:AMT_W];

  sop_imm_unit #(.W(DATA_W)) u_imm (
    .rot_field (f.rot_field),
    .const8    (f.const8),
    .cin       (carry_in),
    .op        (imm_op),
    .cout      (imm_c)
  );

  sop_shift_unit #(.W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .val    (rm_val),
    .kind   (f.kind),
    .amt    (shamt),
    .is_reg (f.reg_amt),
    .cin    (carry_in),
    .op     (sh_op),
    .cout   (sh_c)
  );

  always_comb begin
    if (f.imm_form) begin
      operand_out = imm_op;
      carry_out   = imm_c;
    end else begin
      operand_out = sh_op;
      carry_out   = sh_c;
    end
    extra_cycle = !f.imm_form && f.reg_amt;
  end

endmodule

// File: rtl/sop_gen_chk.sv
module sop_gen_chk #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       instr_word,
  input logic [DATA_W-1:0] rm_val,
  input logic [DATA_W-1:0] rs_val,
  input logic              carry_in,
  input logic [DATA_W-1:0] operand_out,
  input logic              carry_out,
  input logic              extra_cycle
);

  logic       reg_form;
  logic       imm_amt_form;
  logic [1:0] kind;
  logic [7:0] rs_byte;

  assign reg_form     = !instr_word[25] && instr_word[4];
  assign imm_amt_form = !instr_word[25] && !instr_word[4];
  assign kind         = instr_word[6:5];
  assign rs_byte      = rs_val[7:0];

  always_comb begin
    if (!$isunknown({instr_word, rm_val, rs_val, carry_in})) begin
      if (reg_form && rs_byte == 8'd0) begin
        p_regzero_pass_r4: assert (operand_out == rm_val && carry_out == carry_in && extra_cycle)
          else $error("R4 zero register amount altered operand or carry");
      end
      if (reg_form && kind == 2'b00 && rs_byte == 8'd32) begin
        p_left32_r6: assert (operand_out == '0 && carry_out == rm_val[0])
          else $error("R6 left by 32 wrong");
      end
      if (reg_form && kind == 2'b01 && rs_byte > 8'd32) begin
        p_right_big_r7: assert (operand_out == '0 && !carry_out)
          else $error("R7 right beyond 32 wrong");
      end
      if (reg_form && kind == 2'b10 && rs_byte >= 8'd32) begin
        p_arith_fill_r8: assert (operand_out == {DATA_W{rm_val[DATA_W-1]}} && carry_out == rm_val[DATA_W-1])
          else $error("R8 arithmetic fill wrong");
      end
      if (reg_form && kind == 2'b11 && rs_byte != 8'd0 && rs_byte[4:0] == 5'd0) begin
        p_rot_whole_r9: assert (operand_out == rm_val && carry_out == rm_val[DATA_W-1])
          else $error("R9 whole-turn rotate wrong");
      end
      if (imm_amt_form && kind == 2'b11 && instr_word[11:7] == 5'd0) begin
        p_rrx_r11: assert (operand_out == {carry_in, rm_val[DATA_W-1:1]} && carry_out == rm_val[0])
          else $error("R11 extended rotate wrong");
      end
      if (instr_word[25] && instr_word[11:8] == 4'd0) begin
        p_const_keep_r1: assert (operand_out == {{(DATA_W-8){1'b0}}, instr_word[7:0]} && carry_out == carry_in && !extra_cycle)
          else $error("R1 unrotated constant wrong");
      end
    end
  end

endmodule

bind sop_gen sop_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .instr_word  (instr_word),
  .rm_val      (rm_val),
  .rs_val      (rs_val),
  .carry_in    (carry_in),
  .operand_out (operand_out),
  .carry_out   (carry_out),
  .extra_cycle (extra_cycle)
);

// File: tb/tb_sop_gen.sv
module tb_sop_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr_word;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;
  logic        extra_cycle;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  sop_gen dut (
    .instr_word  (instr_word),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out),
    .extra_cycle (extra_cycle)
  );

  // Behavioural reference on 64-bit shifts.
  function automatic void model(input logic [31:0] iw, input logic [31:0] rm,
                                input logic [31:0] rs, input logic ci,
                                output logic [31:0] op, output logic co,
                                output logic xc);
    int          amt;
    int          r;
    int          kind;
    logic [63:0] t;
    logic [31:0] b;
    kind = int'(iw[6:5]);
    xc   = !iw[25] && iw[4];
    op   = rm;
    co   = ci;
    if (iw[25]) begin
      r = 2 * int'(iw[11:8]);
      b = {24'd0, iw[7:0]};
      t = {b, b} >> r;
      op = t[31:0];
      co = (r == 0) ? ci : op[31];
      return;
    end
    amt = iw[4] ? int'(rs[7:0]) : int'(iw[11:7]);
    if (amt == 0 && (iw[4] || kind == 0)) begin
      op = rm;
      co = ci;
      return;
    end
    if (!iw[4] && amt == 0) begin
      if (kind == 3) begin
        op = {ci, rm[31:1]};
        co = rm[0];
        return;
      end
      amt = 32;
    end
    case (kind)
      0: begin
        t  = {32'd0, rm} << amt;
        op = t[31:0];
        co = t[32];
      end
      1: begin
        t  = {rm, 32'd0} >> amt;
        op = t[63:32];
        co = t[31];
      end
      2: begin
        t  = 64'($signed({rm, 32'd0}) >>> amt);
        op = t[63:32];
        co = t[31];
      end
      default: begin
        r = amt % 32;
        if (r == 0) begin
          op = rm;
          co = rm[31];
        end else begin
          t  = {rm, rm} >> r;
          op = t[31:0];
          co = rm[r-1];
        end
      end
    endcase
  endfunction

  function automatic logic [31:0] w_reg(input logic [1:0] k);
    return {6'd0, 1'b0, 9'd0, 4'd3, 4'd1, 1'b0, k, 1'b1, 4'd2};
  endfunction

  function automatic logic [31:0] w_imm(input logic [1:0] k, input logic [4:0] n);
    return {6'd0, 1'b0, 9'd0, 4'd3, n, k, 1'b0, 4'd2};
  endfunction

  function automatic logic [31:0] w_const(input logic [3:0] rot, input logic [7:0] c);
    return {6'd0, 1'b1, 9'd0, 4'd3, rot, c};
  endfunction

  task automatic apply(input logic [31:0] iw, input logic [31:0] rm,
                       input logic [31:0] rs, input logic ci, input string tag);
    logic [31:0] e_op;
    logic        e_c;
    logic        e_x;
    @(posedge clk);
    #1;
    instr_word = iw;
    rm_val     = rm;
    rs_val     = rs;
    carry_in   = ci;
    @(negedge clk);
    model(iw, rm, rs, ci, e_op, e_c, e_x);
    n_cmp++;
    if (operand_out !== e_op || carry_out !== e_c || extra_cycle !== e_x) begin
      n_bad++;
      $display("FAIL %s iw=%h rm=%h rs=%h ci=%b : op=%h exp=%h c=%b exp=%b x=%b exp=%b",
               tag, iw, rm, rs, ci, operand_out, e_op, carry_out, e_c, extra_cycle, e_x);
    end
  endtask

  initial begin
    logic [31:0] v;
    instr_word = '0;
    rm_val     = '0;
    rs_val     = '0;
    carry_in   = 1'b0;
    rst_n      = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero word is an immediate left by 0.
    apply(32'd0, 32'd0, 32'd0, 1'b0, "R2");

    // R1 rotated constants
    apply(w_const(4'd0, 8'hAB), 32'h1234_5678, 32'd0, 1'b1, "R1");
    apply(w_const(4'd0, 8'hAB), 32'h1234_5678, 32'd0, 1'b0, "R1");
    apply(w_const(4'd1, 8'h03), 32'd0, 32'd0, 1'b0, "R1");
    apply(w_const(4'd4, 8'hFF), 32'd0, 32'd0, 1'b0, "R1");
    apply(w_const(4'd15, 8'h01), 32'd0, 32'd0, 1'b1, "R1");
    for (int i = 0; i < 16; i++)
      apply(w_const(4'(i), 8'(i * 37 + 5)), $urandom, 32'd0, 1'(i), "R1");

    // R3 extra cycle flag on each form
    apply(w_reg(2'b01), 32'hF0F0_0000, 32'd4, 1'b0, "R3");
    apply(w_imm(2'b01, 5'd4), 32'hF0F0_0000, 32'd4, 1'b0, "R3");

    // R4 zero register amount, upper Rs bits set on some vectors
    for (int k = 0; k < 4; k++) begin
      apply(w_reg(2'(k)), 32'h8000_0001, 32'h0000_0100, 1'b1, "R4");
      apply(w_reg(2'(k)), 32'h8000_0001, 32'h0000_0000, 1'b0, "R4");
    end

    // R5 nonzero amounts below 32 in both forms
    for (int k = 0; k < 4; k++)
      for (int n = 1; n < 32; n++) begin
        v = $urandom;
        apply(w_imm(2'(k), 5'(n)), v, 32'd0, 1'(n), "R5");
        apply(w_reg(2'(k)), v, 32'(n), 1'(n + 1), "R5");
      end

    // R6 left by 32 and beyond
    apply(w_reg(2'b00), 32'h0000_0001, 32'd32, 1'b0, "R6");
    apply(w_reg(2'b00), 32'hFFFF_FFFE, 32'd32, 1'b1, "R6");
    apply(w_reg(2'b00), 32'hFFFF_FFFF, 32'd33, 1'b1, "R6");
    apply(w_reg(2'b00), 32'hFFFF_FFFF, 32'd255, 1'b1, "R6");

    // R7 right by 32 and beyond
    apply(w_reg(2'b01), 32'h8000_0000, 32'd32, 1'b0, "R7");
    apply(w_reg(2'b01), 32'hFFFF_FFFF, 32'd40, 1'b1, "R7");

    // R8 arithmetic by 32 or more
    apply(w_reg(2'b10), 32'h8000_0000, 32'd32, 1'b0, "R8");
    apply(w_reg(2'b10), 32'h7FFF_FFFF, 32'd200, 1'b1, "R8");
    apply(w_reg(2'b10), 32'h9000_0000, 32'd255, 1'b0, "R8");

    // R9 rotate with zero low five bits
    apply(w_reg(2'b11), 32'h8000_00F0, 32'd32, 1'b0, "R9");
    apply(w_reg(2'b11), 32'h0000_00F0, 32'd64, 1'b1, "R9");
    apply(w_reg(2'b11), 32'h8765_4321, 32'hE0, 1'b0, "R9");
    apply(w_reg(2'b11), 32'h8765_4321, 32'd33, 1'b0, "R9");

    // R10 immediate right forms with amount 0
    apply(w_imm(2'b01, 5'd0), 32'h8000_0001, 32'd0, 1'b0, "R10");
    apply(w_imm(2'b01, 5'd0), 32'h7FFF_FFFF, 32'd0, 1'b1, "R10");
    apply(w_imm(2'b10, 5'd0), 32'h8000_0000, 32'd0, 1'b0, "R10");
    apply(w_imm(2'b10, 5'd0), 32'h7FFF_FFFF, 32'd0, 1'b1, "R10");

    // R11 extended rotate with both carry levels
    apply(w_imm(2'b11, 5'd0), 32'h0000_0003, 32'd0, 1'b1, "R11");
    apply(w_imm(2'b11, 5'd0), 32'hFFFF_FFFE, 32'd0, 1'b0, "R11");

    // R12 immediate left by 0
    apply(w_imm(2'b00, 5'd0), 32'hDEAD_BEEF, 32'd0, 1'b1, "R12");
    apply(w_imm(2'b00, 5'd0), 32'hDEAD_BEEF, 32'd0, 1'b0, "R12");

    // Full sweep of the Rs byte per kind (R4 R6 R7 R8 R9 overlap)
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++)
        apply(w_reg(2'(k)), $urandom, {24'(a * 7), 8'(a)}, 1'(a >> 1), "R9");

    // Random words across all forms
    for (int i = 0; i < 1500; i++)
      apply($urandom, $urandom, $urandom, 1'($urandom), "R2");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d compares", n_cmp);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule